// File: doc/BRIEF.md
# Configuration Readback Scrubber

This block guards a serially loaded configuration string inside an external device against radiation-induced bit upsets. After a programmable number of idle cycles it shifts the device's configuration out one bit per cycle. Each bit is fed straight back into the device, so the contents are not lost while they are read. Every bit is compared with a golden copy that the host wrote into the block beforehand. If any bit differs, the block shifts the whole golden string into the device, pulses a load strobe and at once runs a second readback to confirm the repair. If that confirming pass still finds a difference, a sticky fault flag is raised.

Every readback ends with a one-cycle event. The event carries a cycle timestamp, the number of bits that differed (saturating) and a marker that says whether the pass was a confirming pass. The host can update the golden copy word by word, but only while the block is idle. Writes made while a readback, reload or load is in progress are discarded.

Top module: `cfg_scrubber`

## Requirements
- R1: While reset is held and in the first cycle after it, `dut_shift`, `dut_load`, `host_busy`, `evt_valid` and `fault` are low. Reset is synchronous and active low.
- R2: In the idle state an interval counter starts at 0 and counts once per cycle. The cycle in which it equals `interval` is the last idle cycle, so a readback starts `interval`+1 cycles after the idle state is entered.
- R3: A readback asserts `dut_shift` for exactly CFG_BITS consecutive cycles. In each of those cycles `dut_sdi` is compared with golden bit CFG_BITS-1-k in step k, so the most significant bit comes first. During a readback `dut_sdo` equals `dut_sdi`, so the device contents are preserved.
- R4: The cycle after the last shift of a readback, `evt_valid` is high for one cycle. In that cycle `evt_time` holds the value of a free-running counter as it stood in the last shift cycle; the counter is 0 in the first cycle after reset. `evt_verify` is 1 when the readback was a confirming pass.
- R5: When a normal readback finds at least one differing bit, the block drives golden bits MSB first on `dut_sdo` for CFG_BITS consecutive `dut_shift` cycles. Then it raises `dut_load` for one cycle, with `dut_shift` low in that cycle. Afterwards the device holds the golden string.
- R6: `evt_mismatch` equals the number of differing bits in that readback, saturating at 2^CNT_W-1.
- R7: The cycle after the load strobe, a confirming readback begins. If it finds a difference, `fault` is set and stays set until reset, and no further reload follows that pass.
- R8: A host write with `host_we` high places `host_wdata` into golden bits [`host_addr`*WORD_W +: WORD_W]. It is accepted only when `host_busy` is low. `host_busy` is high during readback, reload and load, and writes made then are discarded.
- R9: A readback with no difference returns to idle without any reload or load strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| interval | input | IV_W | Idle cycles between readbacks, minus one |
| host_we | input | 1 | Golden-copy write strobe |
| host_addr | input | AW | Golden-copy word address |
| host_wdata | input | WORD_W | Golden-copy word data |
| host_busy | output | 1 | Scrub in progress; host writes are discarded |
| dut_shift | output | 1 | Shift enable toward the device, one bit per cycle |
| dut_sdo | output | 1 | Serial data into the device |
| dut_sdi | input | 1 | Serial data out of the device (its current MSB) |
| dut_load | output | 1 | One-cycle strobe that makes the device latch a reloaded string |
| evt_valid | output | 1 | One-cycle readback-complete event |
| evt_time | output | TS_W | Cycle timestamp of the event |
| evt_mismatch | output | CNT_W | Differing-bit count, saturating |
| evt_verify | output | 1 | Event came from a confirming readback |
| fault | output | 1 | Sticky persistent-fault flag |

## Verification
The device is modelled as a shift register whose bits can be flipped on demand. The first readback runs against an empty device while the golden string has more set bits than the count can hold, which exercises saturation together with the reload and the confirming pass. A small injected flip pattern then shows an exact count with a successful repair. Untouched passes show that no reload happens in the clean case, and a write attempt during a scrub shows that busy writes are dropped. A flip injected right at the load strobe separates the persistent-fault path from an ordinary repair, and a change of the interval followed by a measured gap checks the timing of the idle period.

// File: rtl/scrub_pkg.sv
// Shared types for the configuration readback scrubber.
// Assumes nothing beyond the synthesizable SystemVerilog subset.
package scrub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_RELOAD = 2'd2,
        ST_LOAD   = 2'd3
    } scrub_state_e;
endpackage

// File: rtl/scrub_timer.sv
// Interval counter and free-running timestamp.
// fire is high in the idle cycle in which the idle counter equals interval.
// Assumes idle drops for at least one cycle after each fire.
module scrub_timer #(
    parameter int IV_W = 24,
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle,
    input  logic [IV_W-1:0] interval,
    output logic            fire,
    output logic [TS_W-1:0] ts
);
    logic [IV_W-1:0] tick;

    assign fire = idle && (tick == interval);

    // Count idle cycles, restart on fire or outside idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              tick <= '0;
        else if (!idle || fire)  tick <= '0;
        else                     tick <= tick + 1'b1;
    end

    // Free-running cycle timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) ts <= '0;
        else        ts <= ts + 1'b1;
    end

    // R2: a fire always leaves the counter cleared for the next cycle.
    assert_tick_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (tick == '0));
endmodule

// File: rtl/scrub_golden.sv
// Golden-copy storage with a word-wide host write port and a bit read port.
// Writes are discarded while busy is high; out-of-range addresses are ignored.
// Assumes CFG_BITS is a multiple of WORD_W.
module scrub_golden #(
    parameter int CFG_BITS = 64,
    parameter int WORD_W   = 8,
    parameter int AW       = 3,
    parameter int IW       = 6,
    localparam int WORDS   = CFG_BITS / WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              busy,
    input  logic [IW-1:0]     rd_idx,
    output logic              rd_bit
);
    logic [CFG_BITS-1:0] gold;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        // Store one host word when idle and addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                gold[w*WORD_W +: WORD_W] <= '0;
            else if (wr_en && !busy && (wr_addr == AW'(w)))
                gold[w*WORD_W +: WORD_W] <= wr_data;
        end
    end

    assign rd_bit = gold[rd_idx];

    // R8: a write attempted while busy leaves the golden copy untouched.
    assert_busy_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> $stable(gold));
endmodule

// File: rtl/scrub_compare.sv
// Saturating counter of differing bits over one readback.
// cnt_nxt includes the comparison of the current cycle.
// Assumes clr and en are never high together.
module scrub_compare #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             bit_rd,
    input  logic             bit_gold,
    output logic [CNT_W-1:0] cnt_nxt
);
    localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};
    logic [CNT_W-1:0] cnt;

    assign cnt_nxt = (en && (bit_rd != bit_gold) && (cnt != MAXC)) ? cnt + 1'b1 : cnt;

    // Hold the running count for this readback.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt_nxt;
    end

    // R6: once saturated the count stays at its ceiling during the pass.
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && cnt == MAXC) |=> (cnt == MAXC));
endmodule

// File: rtl/cfg_scrubber.sv
// Configuration readback scrubber top.
// Idle -> readback (sdo recirculates sdi) -> on mismatch reload golden MSB first,
// strobe load, then run a confirming readback. A confirming mismatch sets fault.
// Assumes the device shifts left by one on each clk edge with dut_shift high
// and presents its MSB on dut_sdi. CFG_BITS >= 2.
module cfg_scrubber #(
    parameter int CFG_BITS = 64,
    parameter int WORD_W   = 8,
    parameter int CNT_W    = 8,
    parameter int IV_W     = 24,
    parameter int TS_W     = 32,
    localparam int WORDS   = CFG_BITS / WORD_W,
    localparam int AW      = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IW      = $clog2(CFG_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IV_W-1:0]   interval,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              dut_shift,
    output logic              dut_sdo,
    input  logic              dut_sdi,
    output logic              dut_load,
    output logic              evt_valid,
    output logic [TS_W-1:0]   evt_time,
    output logic [CNT_W-1:0]  evt_mismatch,
    output logic              evt_verify,
    output logic              fault
);
    import scrub_pkg::*;

    localparam logic [IW-1:0] LAST = IW'(CFG_BITS - 1);

    scrub_state_e     st;
    logic [IW-1:0]    bitcnt;
    logic             verify;
    logic             fire;
    logic [TS_W-1:0]  ts;
    logic             gold_bit;
    logic [CNT_W-1:0] mm_nxt;
    logic             cmp_clr;

    assign host_busy = (st != ST_IDLE);
    assign dut_shift = (st == ST_READ) || (st == ST_RELOAD);
    assign dut_load  = (st == ST_LOAD);
    assign dut_sdo   = (st == ST_READ) ? dut_sdi : gold_bit;
    assign cmp_clr   = ((st == ST_IDLE) && fire) || (st == ST_LOAD);

    scrub_timer #(.IV_W(IV_W), .TS_W(TS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .idle(st == ST_IDLE),
        .interval(interval), .fire(fire), .ts(ts)
    );

    scrub_golden #(.CFG_BITS(CFG_BITS), .WORD_W(WORD_W), .AW(AW), .IW(IW)) u_golden (
        .clk(clk), .rst_n(rst_n), .wr_en(host_we), .wr_addr(host_addr),
        .wr_data(host_wdata), .busy(host_busy), .rd_idx(LAST - bitcnt),
        .rd_bit(gold_bit)
    );

    scrub_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(cmp_clr), .en(st == ST_READ),
        .bit_rd(dut_sdi), .bit_gold(gold_bit), .cnt_nxt(mm_nxt)
    );

    // Sequence the scrub and register the event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            bitcnt       <= '0;
            verify       <= 1'b0;
            fault        <= 1'b0;
            evt_valid    <= 1'b0;
            evt_time     <= '0;
            evt_mismatch <= '0;
            evt_verify   <= 1'b0;
        end else begin
            evt_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (fire) begin
                        st     <= ST_READ;
                        bitcnt <= '0;
                    end
                end
                ST_READ: begin
                    if (bitcnt == LAST) begin
                        evt_valid    <= 1'b1;
                        evt_time     <= ts;
                        evt_mismatch <= mm_nxt;
                        evt_verify   <= verify;
                        bitcnt       <= '0;
                        if (mm_nxt != '0 && !verify) begin
                            st <= ST_RELOAD;
                        end else begin
                            if (mm_nxt != '0) fault <= 1'b1;
                            st     <= ST_IDLE;
                            verify <= 1'b0;
                        end
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_RELOAD: begin
                    if (bitcnt == LAST) st <= ST_LOAD;
                    else                bitcnt <= bitcnt + 1'b1;
                end
                default: begin
                    st     <= ST_READ;
                    verify <= 1'b1;
                    bitcnt <= '0;
                end
            endcase
        end
    end

    // R5: the load strobe never overlaps a shift.
    assert_load_no_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dut_load |-> !dut_shift);
    // R7: a confirming readback starts right after the load strobe.
    assert_verify_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dut_load |=> (dut_shift && host_busy));
    // R7: the fault flag is sticky.
    assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    // R4: events are single-cycle pulses.
    assert_evt_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);
endmodule

// File: tb/cfg_scrubber_bench.sv
module cfg_scrubber_bench;
    localparam int CB    = 32;
    localparam int WW    = 8;
    localparam int CW    = 4;
    localparam int IVW   = 16;
    localparam int TSW   = 32;
    localparam int NW    = CB / WW;
    localparam int MAXC  = (1 << CW) - 1;
    localparam logic [CB-1:0] GOLD = 32'hA5C3_1E7F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [IVW-1:0] interval = 16'd20;
    logic host_we = 1'b0;
    logic [1:0] host_addr = '0;
    logic [WW-1:0] host_wdata = '0;
    logic host_busy, dut_shift, dut_sdo, dut_sdi, dut_load;
    logic evt_valid, evt_verify, fault;
    logic [TSW-1:0] evt_time;
    logic [CW-1:0] evt_mismatch;

    logic [CB-1:0] dev = '0;
    logic [CB-1:0] inj_mask = '0;

    int checks = 0;
    int errors = 0;
    int load_cnt = 0;
    int last_mm = 0;
    int last_ver = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cfg_scrubber #(.CFG_BITS(CB), .WORD_W(WW), .CNT_W(CW), .IV_W(IVW), .TS_W(TSW)) u_cfg_scrubber (
        .clk(clk), .rst_n(rst_n), .interval(interval), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_busy(host_busy),
        .dut_shift(dut_shift), .dut_sdo(dut_sdo), .dut_sdi(dut_sdi), .dut_load(dut_load),
        .evt_valid(evt_valid), .evt_time(evt_time), .evt_mismatch(evt_mismatch),
        .evt_verify(evt_verify), .fault(fault)
    );

    // Device under scrub: shift register with injectable flips.
    assign dut_sdi = dev[CB-1];
    always @(posedge clk) begin
        if (dut_shift) dev <= {dev[CB-2:0], dut_sdo} ^ inj_mask;
        else           dev <= dev ^ inj_mask;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Behavioural reference model.
    int m_st = 0, m_tick = 0, m_bit = 0, m_mm = 0, m_ver = 0, m_fault = 0;
    int m_evv = 0, m_evmm = 0, m_evver = 0;
    longint m_evt = 0, m_ts = 0;
    bit m_gold [CB];
    initial for (int i = 0; i < CB; i++) m_gold[i] = 1'b0;

    always @(posedge clk) begin
        bit sdi_b;
        if (!rst_n) begin
            m_st = 0; m_tick = 0; m_bit = 0; m_mm = 0; m_ver = 0; m_fault = 0;
            m_evv = 0; m_evt = 0; m_evmm = 0; m_evver = 0; m_ts = 0;
            for (int i = 0; i < CB; i++) m_gold[i] = 1'b0;
        end else begin
            sdi_b = dev[CB-1];
            m_evv = 0;
            case (m_st)
                0: begin
                    if (host_we && int'(host_addr) < NW)
                        for (int i = 0; i < WW; i++) m_gold[int'(host_addr)*WW + i] = host_wdata[i];
                    if (m_tick == int'(interval)) begin
                        m_st = 1; m_tick = 0; m_bit = 0; m_mm = 0;
                    end else m_tick++;
                end
                1: begin
                    if (sdi_b != m_gold[CB-1-m_bit] && m_mm < MAXC) m_mm++;
                    if (m_bit == CB-1) begin
                        m_evv = 1; m_evt = m_ts; m_evmm = m_mm; m_evver = m_ver;
                        m_bit = 0;
                        if (m_mm != 0 && m_ver == 0) m_st = 2;
                        else begin
                            if (m_mm != 0) m_fault = 1;
                            m_st = 0; m_ver = 0;
                        end
                    end else m_bit++;
                end
                2: begin
                    if (m_bit == CB-1) m_st = 3; else m_bit++;
                end
                default: begin
                    m_st = 1; m_ver = 1; m_bit = 0; m_mm = 0;
                end
            endcase
            m_ts++;
        end
    end

    // Compare DUT with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(dut_shift == (m_st == 1 || m_st == 2), "R3 shift", dut_shift, (m_st == 1 || m_st == 2));
            check(dut_load == (m_st == 3), "R5 load", dut_load, (m_st == 3));
            check(host_busy == (m_st != 0), "R8 busy", host_busy, (m_st != 0));
            check(evt_valid == m_evv[0], "R4 evt_valid", evt_valid, m_evv);
            check(fault == m_fault[0], "R7 fault", fault, m_fault);
            if (m_evv != 0) begin
                check(evt_time == TSW'(m_evt), "R4 evt_time", evt_time, m_evt);
                check(evt_mismatch == CW'(m_evmm), "R6 evt_mismatch", evt_mismatch, m_evmm);
                check(evt_verify == m_evver[0], "R4 evt_verify", evt_verify, m_evver);
            end
            if (m_st == 2) check(dut_sdo == m_gold[CB-1-m_bit], "R5 reload data", dut_sdo, m_gold[CB-1-m_bit]);
            if (m_st == 1) check(dut_sdo == dev[CB-1], "R3 recirculate", dut_sdo, dev[CB-1]);
            if (dut_load) load_cnt++;
        end
    end

    task automatic wait_evt();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (evt_valid) begin
                last_mm = int'(evt_mismatch);
                last_ver = int'(evt_verify);
                return;
            end
        end
        check(1'b0, "R4 event timeout", 0, 1);
    endtask

    task automatic inject(input logic [CB-1:0] m);
        inj_mask = m;
        @(negedge clk);
        inj_mask = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int loads_before;
        int gap;
        repeat (3) @(negedge clk);
        check(!dut_shift && !dut_load && !host_busy && !evt_valid && !fault, "R1 in reset",
              {dut_shift, dut_load, host_busy, evt_valid, fault}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!dut_shift && !dut_load && !host_busy && !evt_valid && !fault, "R1 after reset",
              {dut_shift, dut_load, host_busy, evt_valid, fault}, 0);
        // R8: load golden while idle
        for (int w = 0; w < NW; w++) begin
            host_we = 1'b1; host_addr = 2'(w); host_wdata = GOLD[w*WW +: WW];
            @(negedge clk);
        end
        host_we = 1'b0;
        // R6: empty device vs 19 set bits saturates
        wait_evt();
        check(last_mm == MAXC && last_ver == 0, "R6 saturated count", last_mm, MAXC);
        wait_evt();
        check(last_ver == 1 && last_mm == 0, "R7 confirming pass clean", last_mm, 0);
        check(dev == GOLD, "R5 device repaired", dev, GOLD);
        // R6: three flips give an exact count
        inject(32'h8001_0200);
        wait_evt();
        check(last_mm == 3 && last_ver == 0, "R6 exact count", last_mm, 3);
        wait_evt();
        check(dev == GOLD && last_ver == 1, "R5 repaired after flips", dev, GOLD);
        // R9: clean pass, no load
        loads_before = load_cnt;
        wait_evt();
        check(last_mm == 0 && last_ver == 0, "R9 clean count", last_mm, 0);
        repeat (3) @(negedge clk);
        check(load_cnt == loads_before, "R9 no load on clean pass", load_cnt, loads_before);
        // R8: write during busy is dropped
        while (!host_busy) @(negedge clk);
        host_we = 1'b1; host_addr = 2'd3; host_wdata = 8'h00;
        @(negedge clk);
        host_we = 1'b0;
        wait_evt();
        wait_evt();
        check(last_mm == 0 && dev == GOLD, "R8 busy write ignored", last_mm, 0);
        // R7: flip at the load strobe makes the confirming pass fail
        inject(32'h0000_0001);
        while (!dut_load) @(negedge clk);
        inject(32'h0000_00F0);
        wait_evt();
        check(last_ver == 1 && last_mm == 4 && fault, "R7 fault raised", last_mm, 4);
        wait_evt();
        check(last_ver == 0 && last_mm == 4, "R7 no reload after confirm fail", last_mm, 4);
        wait_evt();
        check(fault && dev == GOLD, "R7 fault sticky", fault, 1);
        // R2: shorter interval, measure the idle gap
        interval = 16'd5;
        wait_evt();
        gap = 0;
        while (!dut_shift && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        check(gap == 6, "R2 idle gap", gap, 6);
        // R1: reset clears the fault
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!fault && !host_busy && !dut_shift, "R1 reset clears fault", fault, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule